// File: doc/BRIEF.md
# PDM Microphone Output Stage Model

This block models the digital output side of a single pulse-density-modulated microphone, for use in board-level benches or FPGA loopback rigs. It watches a shared bit clock that arrives from outside. It brings that clock into a fast free-running reference clock domain and detects both of its edges there. A select pin decides which half of each bit period belongs to this microphone. The block drives its bit during that half and floats the line for the other half, so two instances can share one data wire.

The bit comes from a first-order delta-sigma stage fed by a signed level input. Full scale is defined by ones density: the largest positive level gives a stream of all ones and the most negative level gives all zeros. When the bit clock stops, or slows below the sleep threshold, the block enters sleep and floats its output. When edges return, it keeps the line floating for a wake-up delay. It then starts driving modulator data at the first complete bit period that follows. The tri-state line is represented by a data value and an output enable. The level input is a plain control input with no handshake. The block samples it at each launch edge.

Top module: `pdm_mic_emu`

## Requirements
- R1: With `chan_sel` low, the block launches on the falling edge of `bclk`. While the block is running, `pdm_oe` rises within 4 reference cycles after a falling edge and stays high until the next rising edge.
- R2: After the edge opposite to the launch edge, `pdm_oe` is low within 4 reference cycles, and it stays low until the next launch edge.
- R3: With `chan_sel` high, the block launches on the rising edge of `bclk` and releases the line on the falling edge.
- R4: If no `bclk` edge is seen for SLEEP_CYC reference cycles, the block enters sleep, and `pdm_oe` is low one cycle later. While the block is asleep, `pdm_oe` stays low, even if it was high when the clock stopped.
- R5: After the first `bclk` edge seen in sleep, `pdm_oe` stays low for at least WAKE_CYC reference cycles. The block then drives at the launch edge that follows the next release edge. It always passes through a waiting state between the wake delay and driving.
- R6: The bit rule is defined as follows. Let FS = 2^LEVEL_W - 2, and let u = level + 2^(LEVEL_W-1) - 1, clamped to a minimum of 0. An accumulator starts at 0 each time the block enters driving. At each launch it forms s = acc + u. The bit is 1 when s >= FS, in which case acc becomes s - FS; otherwise acc becomes s.
- R7: Full scale is set by ones density. The level 2^(LEVEL_W-1)-1 gives all ones. The levels -(2^(LEVEL_W-1)-1) and -2^(LEVEL_W-1) give all zeros. A level of 0 gives the sequence 0,1,0,1 and so on, starting with 0.
- R8: The level present at a launch edge sets the bit launched on that edge. `pdm_data` changes only in the cycle after a detected launch edge, so latency is a few reference cycles, far below 30 µs.
- R9: During and after reset, `pdm_oe` is low and the block is asleep until the first `bclk` edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Shared bit clock from the receiver, asynchronous to ref_clk |
| chan_sel | input | 1 | Channel select: 0 launches on falling edge, 1 on rising edge |
| level | input | LEVEL_W | Signed input level for the modulator |
| pdm_data | output | 1 | Bit value for the shared data line |
| pdm_oe | output | 1 | Output enable; low means the line floats |

## Verification
The hardest situation to reach from the ports is a clock stop that leaves the output driven. The line is still enabled because no release edge ever arrives, and only the sleep timeout may clear it. The stimulus ends each session right after a launch half-period and leaves the clock parked there, then checks that the enable falls and stays low. A second hard point is the start of driving after wake-up, whose exact period depends on synchronizer phase. The scoreboard marks the periods near that boundary as either floating or live. When it sees the output driven, it restarts its own accumulator so that the bit sequence that follows is checked exactly.

// File: rtl/pdm_emu_pkg.sv
package pdm_emu_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_ARM   = 2'd2,
    ST_RUN   = 2'd3
  } pdm_state_e;
endpackage

// File: rtl/pdm_edge_sync.sv
// Brings an asynchronous clock into the local domain and flags its edges.
module pdm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_p,
  output logic fall_p
);
  // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], async_in};
  end

  assign rise_p =  sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall_p = ~sh[SYNC_STAGES-1] &  sh[SYNC_STAGES];
endmodule

// File: rtl/pdm_clk_monitor.sv
// Tracks bit-clock activity and sequences sleep, wake delay and running.
module pdm_clk_monitor
  import pdm_emu_pkg::*;
#(
  parameter int SLEEP_CYC = 100000,
  parameter int WAKE_CYC  = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_edge,
  input  logic       release_p,
  output pdm_state_e state
);
  localparam int IW = $clog2(SLEEP_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);

  logic [IW-1:0] idle_cnt;
  logic [WW-1:0] wake_cnt;
  logic          timeout;

  assign timeout = !any_edge && (idle_cnt == IW'(SLEEP_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (any_edge) begin
      idle_cnt <= '0;
    end else if (idle_cnt != IW'(SLEEP_CYC - 1)) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_SLEEP;
      wake_cnt <= '0;
    end else begin
      unique case (state)
        ST_SLEEP: begin
          wake_cnt <= '0;
          if (any_edge) state <= ST_WAKE;
        end
        ST_WAKE: begin
          if (timeout)                              state <= ST_SLEEP;
          else if (wake_cnt == WW'(WAKE_CYC - 1))   state <= ST_ARM;
          else                                      wake_cnt <= wake_cnt + 1'b1;
        end
        ST_ARM: begin
          if (timeout)        state <= ST_SLEEP;
          else if (release_p) state <= ST_RUN;
        end
        ST_RUN: begin
          if (timeout) state <= ST_SLEEP;
        end
        default: state <= ST_SLEEP;
      endcase
    end
  end
endmodule

// File: rtl/pdm_dsm1.sv
// First-order delta-sigma stage with ones-density full scale.
module pdm_dsm1 #(
  parameter int LEVEL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [LEVEL_W-1:0] level,
  output logic               bit_o
);
  localparam int SW   = LEVEL_W + 1;
  localparam int FS   = (1 << LEVEL_W) - 2;
  localparam int BIAS = (1 << (LEVEL_W - 1)) - 1;

  logic [LEVEL_W-1:0] acc;
  logic [SW-1:0]      biased;
  logic [LEVEL_W-1:0] u;
  logic [SW-1:0]      sum;

  always_comb begin
    biased = {level[LEVEL_W-1], level} + SW'(BIAS);
    u      = biased[SW-1] ? '0 : biased[LEVEL_W-1:0];
    sum    = {1'b0, acc} + {1'b0, u};
    bit_o  = (sum >= SW'(FS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc <= '0;
    end else if (step) begin
      acc <= bit_o ? LEVEL_W'(sum - SW'(FS)) : sum[LEVEL_W-1:0];
    end
  end
endmodule

// File: rtl/pdm_mic_emu.sv
module pdm_mic_emu
  import pdm_emu_pkg::*;
#(
  parameter int LEVEL_W     = 16,
  parameter int SLEEP_CYC   = 100000,
  parameter int WAKE_CYC    = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               bclk,
  input  logic               chan_sel,
  input  logic [LEVEL_W-1:0] level,
  output logic               pdm_data,
  output logic               pdm_oe
);
  logic       rise_p, fall_p;
  logic       launch_p, release_p, any_edge;
  logic       mod_bit;
  pdm_state_e state;

  pdm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .async_in(bclk),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  assign launch_p  = chan_sel ? rise_p : fall_p;
  assign release_p = chan_sel ? fall_p : rise_p;
  assign any_edge  = rise_p | fall_p;

  pdm_clk_monitor #(.SLEEP_CYC(SLEEP_CYC), .WAKE_CYC(WAKE_CYC)) u_mon (
    .clk(ref_clk), .rst_n(rst_n), .any_edge(any_edge),
    .release_p(release_p), .state(state)
  );

  pdm_dsm1 #(.LEVEL_W(LEVEL_W)) u_dsm (
    .clk(ref_clk), .rst_n(rst_n),
    .clear(state != ST_RUN),
    .step((state == ST_RUN) && launch_p),
    .level(level), .bit_o(mod_bit)
  );

  always_ff @(posedge ref_clk) begin
    if (!rst_n) begin
      pdm_oe   <= 1'b0;
      pdm_data <= 1'b0;
    end else if (state != ST_RUN) begin
      pdm_oe   <= 1'b0;
    end else if (launch_p) begin
      pdm_oe   <= 1'b1;
      pdm_data <= mod_bit;
    end else if (release_p) begin
      pdm_oe   <= 1'b0;
    end
  end
endmodule

// File: rtl/pdm_mic_emu_chk.sv
module pdm_mic_emu_chk
  import pdm_emu_pkg::*;
(
  input logic       ref_clk,
  input logic       rst_n,
  input pdm_state_e state,
  input logic       launch_p,
  input logic       release_p,
  input logic       pdm_oe,
  input logic       pdm_data
);
  // R4: asleep means floating on the next cycle
  a_r4_sleep_float: assert property (@(posedge ref_clk) disable iff (!rst_n)
    state == ST_SLEEP |=> !pdm_oe);

  // R5: wake delay keeps the line floating
  a_r5_wake_float: assert property (@(posedge ref_clk) disable iff (!rst_n)
    state == ST_WAKE |=> !pdm_oe);

  // R5: driving is only entered from the waiting state
  a_r5_run_via_arm: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(state) == ST_ARM);

  // R2: release edge floats the line
  a_r2_release_float: assert property (@(posedge ref_clk) disable iff (!rst_n)
    release_p |=> !pdm_oe);

  // R1: enable only turns on after a launch edge
  a_r1_launch_only: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(pdm_oe) |-> $past(launch_p));

  // R8: data moves only after a launch edge
  a_r8_data_on_launch: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !$stable(pdm_data) |-> $past(launch_p));
endmodule

bind pdm_mic_emu pdm_mic_emu_chk chk_i (
  .ref_clk(ref_clk), .rst_n(rst_n), .state(state),
  .launch_p(launch_p), .release_p(release_p),
  .pdm_oe(pdm_oe), .pdm_data(pdm_data)
);

// File: tb/pdm_mic_emu_tb_top.sv
`timescale 1ns/1ps
module pdm_mic_emu_tb_top;
  localparam int W     = 8;
  localparam int SLEEP = 40;
  localparam int WAKE  = 100;
  localparam int FS    = (1 << W) - 2;
  localparam int BIAS  = (1 << (W - 1)) - 1;

  logic         ref_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic         bclk    = 1'b0;
  logic         chan_sel = 1'b0;
  logic [W-1:0] level   = '0;
  logic         pdm_data, pdm_oe;

  always #5 ref_clk = ~ref_clk;

  pdm_mic_emu #(.LEVEL_W(W), .SLEEP_CYC(SLEEP), .WAKE_CYC(WAKE)) dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .bclk(bclk), .chan_sel(chan_sel),
    .level(level), .pdm_data(pdm_data), .pdm_oe(pdm_oe)
  );

  typedef struct { int kind; int lvl; bit sel; bit rel; } item_t; // kind: 0 float, 1 live, 2 either
  item_t q[$];
  event  launch_ev;
  int    total = 0, fails = 0;
  bit    done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // driver: one bit period, launch edge in the middle
  task automatic run_period(int lvl, int kind, bit rel);
    item_t it;
    level = W'(lvl);
    bclk  = ~chan_sel;
    #60;
    bclk  = chan_sel;
    it.kind = kind; it.lvl = lvl; it.sel = chan_sel; it.rel = rel;
    q.push_back(it);
    -> launch_ev;
    #60;
  endtask

  function automatic int lvl_s1(int k);
    if (k < 20) return 0;
    if (k < 30) return BIAS;
    if (k < 40) return -(BIAS + 1);
    return 64;
  endfunction

  function automatic int lvl_s2(int k);
    if (k < 25) return -64;
    if (k < 32) return -BIAS;
    return BIAS;
  endfunction

  task automatic session(int n, bit use_s2);
    for (int k = 0; k < n; k++) begin
      int kind;
      kind = (k <= 7) ? 0 : ((k <= 10) ? 2 : 1);
      run_period(use_s2 ? lvl_s2(k) : lvl_s1(k), kind, k != n - 1);
    end
  endtask

  // monitor / scoreboard
  initial begin
    int macc = 0;
    int prev = 0;
    forever begin
      item_t it;
      @(launch_ev);
      it = q.pop_front();
      #52;
      if (it.kind == 0) begin
        chk(pdm_oe == 1'b0, "R5 float during wake", pdm_oe, 0);
        macc = 0;
      end else if (it.kind == 2 && pdm_oe == 1'b0) begin
        macc = 0;
      end else begin
        int u, s, e;
        string tag;
        chk(pdm_oe == 1'b1, it.sel ? "R3 drive on rising" : "R1 drive on falling", pdm_oe, 1);
        u = it.lvl + BIAS;
        if (u < 0) u = 0;
        s = macc + u;
        e = (s >= FS) ? 1 : 0;
        macc = e ? s - FS : s;
        if (it.lvl == BIAS || it.lvl <= -BIAS) tag = "R7 full scale bit";
        else if (it.lvl != prev)               tag = "R8 new level bit";
        else                                   tag = "R6 modulator bit";
        chk(pdm_data == e[0], tag, pdm_data, e);
        prev = it.lvl;
      end
      #60;
      if (it.rel) chk(pdm_oe == 1'b0, "R2 float other half", pdm_oe, 0);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge ref_clk);
    chk(pdm_oe == 1'b0, "R9 oe in reset", pdm_oe, 0);
    rst_n = 1'b1;
    #200;
    chk(pdm_oe == 1'b0, "R9 oe after reset", pdm_oe, 0);

    chan_sel = 1'b0;
    session(50, 1'b0);
    // clock parked after a launch: only sleep may release the line
    #500;
    chk(pdm_oe == 1'b0, "R4 sleep floats parked line", pdm_oe, 0);
    #500;
    chk(pdm_oe == 1'b0, "R4 still asleep", pdm_oe, 0);

    chan_sel = 1'b1;
    session(40, 1'b1);
    #500;
    chk(pdm_oe == 1'b0, "R4 sleep after rising channel", pdm_oe, 0);
    #200;
    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule